// File: doc/BRIEF.md
# Double-Data-Rate Write Burst Command Sequencer

This block sits between a memory controller's request queue and the command and data pins of a double-data-rate memory with several banks. It takes write, read and precharge requests one at a time through a valid/ready handshake. For each request it picks the clock edge on which the command may go out, and it holds the request stalled until that edge is legal. Write data leaves the block as element pairs, one pair per clock. A data-mask bit goes with each element of the pair.

A write request carries a count of wanted pairs. The pairs of the burst that come after that count are still driven, but they are masked. This truncated tail lets a read or a precharge go out early without corrupting the array. A new write may be accepted on any cycle, and its pairs take over from the next cycle, so back-to-back bursts form a continuous stream. Reads wait out the write-to-read gap after the last wanted pair. Precharges wait out the write-recovery gap of their own bank. Any command to a bank that has just been precharged waits out the precharge gap.

Top module: `ddrw_seq`

## Requirements
- R1: While reset is high, and on the first cycle after it, the command output is NOP (code 0), the bank output is 0, and output-enable, data-valid, mask and data outputs are all zero.
- R2: A request accepted at a rising edge shows on the command and bank outputs from that edge for one cycle, with codes NOP=0, WRITE=1, READ=2, PRECHARGE=3. In every other cycle the command output is NOP and the bank output is 0.
- R3: After a WRITE command cycle, output-enable is high for the next BL/2 cycles. In each of those cycles the data output carries the pair present on the write-data input at that edge.
- R4: The wanted-pairs field of a WRITE (values 1 to BL/2; 0 or more than BL/2 means BL/2) sets how many leading pairs go out with data-valid high and mask 2'b00. The remaining pairs of that burst go out with data-valid low and mask 2'b11.
- R5: A WRITE may be accepted in any cycle, including while an earlier burst still has pairs left. The earlier burst stops after the pair driven at the accepting edge, and the new burst's first pair follows in the next cycle with no gap.
- R6: A READ is accepted only when no wanted pair remains to be driven and at least TWTR full cycles separate the last wanted pair's cycle from the READ command cycle.
- R7: A PRECHARGE to bank b is accepted only when no wanted pair for bank b remains and at least TWR full cycles separate the last wanted pair for bank b from the PRECHARGE command cycle. Wanted pairs of other banks do not delay it.
- R8: After a PRECHARGE to bank b, no WRITE, READ or PRECHARGE to bank b is accepted until at least TRP full cycles separate the two command cycles.
- R9: In a cycle with no burst pair, output-enable is low and the data output is zero whatever the write-data input carries.
- R10: Ready is low exactly while the presented command is not legal. A stalled request issues nothing: the command output stays NOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request may be taken at this edge |
| req_cmd | input | 2 | Requested command code |
| req_bank | input | $clog2(NB) | Target bank |
| req_len | input | $clog2(BL/2+1)+1 | Wanted pairs of a WRITE |
| wdata | input | 2*DW | Write data pair for the current cycle |
| cmd_o | output | 2 | Issued command code |
| bank_o | output | $clog2(NB) | Bank of issued command |
| dq_oe_o | output | 1 | Data bus driven |
| dval_o | output | 1 | Driven pair is stored in the array |
| dm_o | output | 2 | Mask bit per element of the pair |
| dq_o | output | 2*DW | Driven data pair |

## Verification
The command and bank outputs change at the same edge that accepts a request. Write pairs follow at the next BL/2 edges. Ready is combinational from the presented request and the timing state. The reference model keeps, for each future edge, the pair slot that a WRITE has scheduled, and it computes legality from the edge numbers of past wanted pairs and past precharges. Ready is compared just before each rising edge, and all registered outputs are compared at the falling edge against the slot the model holds for the edge just taken.

// File: rtl/ddrw_pkg.sv
package ddrw_pkg;
  typedef enum logic [1:0] {
    CMD_NOP = 2'd0,
    CMD_WR  = 2'd1,
    CMD_RD  = 2'd2,
    CMD_PRE = 2'd3
  } cmd_e;
endpackage

// File: rtl/ddrw_burst_ctrl.sv
// Write pair stream: pair counters, mask window, write-to-read gap.
module ddrw_burst_ctrl #(
  parameter int PAIRS = 2,
  parameter int LENW  = 3,
  parameter int DW    = 8,
  parameter int BW    = 2,
  parameter int TWTR  = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_go,
  input  logic [LENW-1:0] wr_len,
  input  logic [BW-1:0]   wr_bank,
  input  logic [2*DW-1:0] wdata,
  output logic            want_busy,
  output logic            wtr_clear,
  output logic [BW-1:0]   cur_bank,
  output logic            rec_pulse,
  output logic            oe_o,
  output logic            dval_o,
  output logic [1:0]      dm_o,
  output logic [2*DW-1:0] dq_o
);
  localparam int PCW = $clog2(PAIRS + 1);
  localparam int WCW = $clog2(TWTR + 2);

  logic [PCW-1:0] wr_left;
  logic [PCW-1:0] want_left;
  logic [PCW-1:0] len_eff;
  logic [WCW-1:0] wtr_cnt;

  always_comb begin
    if (wr_len == '0 || wr_len > LENW'(PAIRS)) len_eff = PCW'(PAIRS);
    else                                       len_eff = PCW'(wr_len);
  end

  // The pair driven at this edge is the last wanted one of its burst.
  assign rec_pulse = (want_left == PCW'(1)) || (wr_go && want_left != '0);
  assign want_busy = (want_left != '0);
  assign wtr_clear = (want_left == '0) && (wtr_cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_left   <= '0;
      want_left <= '0;
      cur_bank  <= '0;
      wtr_cnt   <= '0;
      oe_o      <= 1'b0;
      dval_o    <= 1'b0;
      dm_o      <= 2'b00;
      dq_o      <= '0;
    end else begin
      if (wr_left != '0) begin
        oe_o   <= 1'b1;
        dval_o <= (want_left != '0);
        dm_o   <= (want_left != '0) ? 2'b00 : 2'b11;
        dq_o   <= wdata;
      end else begin
        oe_o   <= 1'b0;
        dval_o <= 1'b0;
        dm_o   <= 2'b00;
        dq_o   <= '0;
      end
      if (wr_go) begin
        wr_left   <= PCW'(PAIRS);
        want_left <= len_eff;
        cur_bank  <= wr_bank;
      end else begin
        if (wr_left != '0)   wr_left   <= wr_left - PCW'(1);
        if (want_left != '0) want_left <= want_left - PCW'(1);
      end
      if (rec_pulse)            wtr_cnt <= WCW'(TWTR);
      else if (wtr_cnt != '0)   wtr_cnt <= wtr_cnt - WCW'(1);
    end
  end

  AST_TAIL_MASKED: assert property (@(posedge clk) disable iff (rst)
    (wr_left != '0 && want_left == '0) |=> (dm_o == 2'b11 && !dval_o)); // R4
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    (wr_left == '0) |=> (!oe_o && dq_o == '0 && dm_o == 2'b00)); // R9
  AST_WANT_WITHIN_BURST: assert property (@(posedge clk) disable iff (rst)
    (want_left <= wr_left)); // R4
endmodule

// File: rtl/ddrw_bank_timer.sv
// Per-bank write-recovery and precharge down-counters.
module ddrw_bank_timer #(
  parameter int NB  = 4,
  parameter int BW  = 2,
  parameter int TWR = 3,
  parameter int TRP = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          pre_go,
  input  logic [BW-1:0] pre_bank,
  input  logic          rec_go,
  input  logic [BW-1:0] rec_bank,
  output logic [NB-1:0] rp_idle,
  output logic [NB-1:0] wr_idle
);
  localparam int RCW = $clog2(TRP + 2);
  localparam int WCW = $clog2(TWR + 2);

  for (genvar g = 0; g < NB; g++) begin : g_bank
    logic [RCW-1:0] rp_cnt;
    logic [WCW-1:0] wr_cnt;
    logic           pre_hit;
    logic           rec_hit;

    assign pre_hit    = pre_go && (pre_bank == BW'(g));
    assign rec_hit    = rec_go && (rec_bank == BW'(g));
    assign rp_idle[g] = (rp_cnt == '0);
    assign wr_idle[g] = (wr_cnt == '0);

    always_ff @(posedge clk) begin
      if (rst) begin
        rp_cnt <= '0;
        wr_cnt <= '0;
      end else begin
        if (pre_hit)              rp_cnt <= RCW'(TRP);
        else if (rp_cnt != '0)    rp_cnt <= rp_cnt - RCW'(1);
        if (rec_hit)              wr_cnt <= WCW'(TWR);
        else if (wr_cnt != '0)    wr_cnt <= wr_cnt - WCW'(1);
      end
    end

    AST_PRE_AFTER_RECOVERY: assert property (@(posedge clk) disable iff (rst)
      pre_hit |-> (wr_cnt == '0 && rp_cnt == '0)); // R7
    AST_NO_RECOVERY_DURING_RP: assert property (@(posedge clk) disable iff (rst)
      rec_hit |-> !pre_hit); // R8
  end
endmodule

// File: rtl/ddrw_issue.sv
// Legality decision and registered command output.
module ddrw_issue
  import ddrw_pkg::*;
#(
  parameter int NB = 4,
  parameter int BW = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  input  logic [1:0]    req_cmd,
  input  logic [BW-1:0] req_bank,
  input  logic          want_busy,
  input  logic          wtr_clear,
  input  logic [BW-1:0] cur_bank,
  input  logic [NB-1:0] rp_idle,
  input  logic [NB-1:0] wr_idle,
  output logic          req_ready,
  output logic          wr_go,
  output logic          pre_go,
  output logic [1:0]    cmd_o,
  output logic [BW-1:0] bank_o
);
  logic legal;
  logic accept;

  always_comb begin
    case (cmd_e'(req_cmd))
      CMD_WR:  legal = rp_idle[req_bank];
      CMD_RD:  legal = rp_idle[req_bank] && wtr_clear;
      CMD_PRE: legal = rp_idle[req_bank] && wr_idle[req_bank] &&
                       !(want_busy && cur_bank == req_bank);
      default: legal = 1'b1;
    endcase
  end

  assign req_ready = legal;
  assign accept    = req_valid && legal;
  assign wr_go     = accept && (req_cmd == CMD_WR);
  assign pre_go    = accept && (req_cmd == CMD_PRE);

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_o  <= CMD_NOP;
      bank_o <= '0;
    end else if (accept) begin
      cmd_o  <= req_cmd;
      bank_o <= req_bank;
    end else begin
      cmd_o  <= CMD_NOP;
      bank_o <= '0;
    end
  end

  AST_STALL_ISSUES_NOP: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_ready) |=> (cmd_o == CMD_NOP)); // R10
endmodule

// File: rtl/ddrw_seq.sv
module ddrw_seq
  import ddrw_pkg::*;
#(
  parameter int BL   = 4,
  parameter int NB   = 4,
  parameter int DW   = 8,
  parameter int TWTR = 2,
  parameter int TWR  = 3,
  parameter int TRP  = 3,
  localparam int PAIRS = BL / 2,
  localparam int BW    = $clog2(NB),
  localparam int LENW  = $clog2(PAIRS + 1) + 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [1:0]      req_cmd,
  input  logic [BW-1:0]   req_bank,
  input  logic [LENW-1:0] req_len,
  input  logic [2*DW-1:0] wdata,
  output logic [1:0]      cmd_o,
  output logic [BW-1:0]   bank_o,
  output logic            dq_oe_o,
  output logic            dval_o,
  output logic [1:0]      dm_o,
  output logic [2*DW-1:0] dq_o
);
  logic          wr_go;
  logic          pre_go;
  logic          want_busy;
  logic          wtr_clear;
  logic          rec_pulse;
  logic [BW-1:0] cur_bank;
  logic [NB-1:0] rp_idle;
  logic [NB-1:0] wr_idle;

  ddrw_issue #(.NB(NB), .BW(BW)) u_issue (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_cmd(req_cmd),
    .req_bank(req_bank), .want_busy(want_busy), .wtr_clear(wtr_clear),
    .cur_bank(cur_bank), .rp_idle(rp_idle), .wr_idle(wr_idle),
    .req_ready(req_ready), .wr_go(wr_go), .pre_go(pre_go),
    .cmd_o(cmd_o), .bank_o(bank_o)
  );

  ddrw_burst_ctrl #(.PAIRS(PAIRS), .LENW(LENW), .DW(DW), .BW(BW), .TWTR(TWTR)) u_burst (
    .clk(clk), .rst(rst), .wr_go(wr_go), .wr_len(req_len), .wr_bank(req_bank),
    .wdata(wdata), .want_busy(want_busy), .wtr_clear(wtr_clear),
    .cur_bank(cur_bank), .rec_pulse(rec_pulse), .oe_o(dq_oe_o),
    .dval_o(dval_o), .dm_o(dm_o), .dq_o(dq_o)
  );

  ddrw_bank_timer #(.NB(NB), .BW(BW), .TWR(TWR), .TRP(TRP)) u_timer (
    .clk(clk), .rst(rst), .pre_go(pre_go), .pre_bank(req_bank),
    .rec_go(rec_pulse), .rec_bank(cur_bank), .rp_idle(rp_idle), .wr_idle(wr_idle)
  );

  AST_READ_NO_LIVE_DATA: assert property (@(posedge clk) disable iff (rst)
    (cmd_o == CMD_RD) |-> !dval_o); // R6
  AST_WRITE_OPENS_BUS: assert property (@(posedge clk) disable iff (rst)
    (cmd_o == CMD_WR) |=> dq_oe_o); // R3
  AST_VALID_NEEDS_BUS: assert property (@(posedge clk) disable iff (rst)
    dval_o |-> (dq_oe_o && dm_o == 2'b00)); // R4
endmodule

// File: tb/ddrw_seq_tb_top.sv
module ddrw_seq_tb_top;
  localparam int BL = 4, NB = 4, DW = 8, TWTR = 2, TWR = 3, TRP = 3;
  localparam int PAIRS = BL / 2;
  localparam int BW    = $clog2(NB);
  localparam int LENW  = $clog2(PAIRS + 1) + 1;
  localparam int MAXE  = 8192;

  logic            clk = 1'b0;
  logic            rst;
  logic            req_valid;
  logic            req_ready;
  logic [1:0]      req_cmd;
  logic [BW-1:0]   req_bank;
  logic [LENW-1:0] req_len;
  logic [2*DW-1:0] wdata;
  logic [1:0]      cmd_o;
  logic [BW-1:0]   bank_o;
  logic            dq_oe_o;
  logic            dval_o;
  logic [1:0]      dm_o;
  logic [2*DW-1:0] dq_o;

  always #10 clk = ~clk;

  ddrw_seq #(.BL(BL), .NB(NB), .DW(DW), .TWTR(TWTR), .TWR(TWR), .TRP(TRP)) dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_cmd(req_cmd), .req_bank(req_bank), .req_len(req_len), .wdata(wdata),
    .cmd_o(cmd_o), .bank_o(bank_o), .dq_oe_o(dq_oe_o), .dval_o(dval_o),
    .dm_o(dm_o), .dq_o(dq_o)
  );

  int checks = 0;
  int errors = 0;
  int n = 0;
  bit acc;
  bit sv [MAXE];
  bit sm [MAXE];
  int sb [MAXE];
  int pre_edge [NB];

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic bit wanted(input int lo, input int hi, input int b, input bit anyb);
    for (int s = lo; s <= hi; s++)
      if (s >= 0 && s < MAXE && sv[s] && !sm[s] && (anyb || sb[s] == b)) return 1'b1;
    return 1'b0;
  endfunction

  function automatic bit legal(input int c, input int b);
    bit rp_ok;
    rp_ok = (n >= pre_edge[b] + TRP + 1);
    case (c)
      1:       return rp_ok;
      2:       return rp_ok && !wanted(n - TWTR, n + PAIRS, b, 1'b1);
      3:       return rp_ok && !wanted(n - TWR, n + PAIRS, b, 1'b0);
      default: return 1'b1;
    endcase
  endfunction

  function automatic string rtag(input int c);
    case (c)
      1:       return "R8";
      2:       return "R6";
      3:       return "R7";
      default: return "R10";
    endcase
  endfunction

  // One clock: enter and leave at a falling edge.
  task automatic step();
    bit mr;
    int e_cmd, e_bank, e_dm, leff;
    bit e_oe, e_dv;
    logic [2*DW-1:0] e_dq;
    wdata = 16'($urandom);
    #1;
    mr = legal(int'(req_cmd), int'(req_bank));
    chk(req_ready == mr, rtag(int'(req_cmd)), "ready", req_ready, mr);
    @(posedge clk);
    acc    = req_valid && mr;
    e_cmd  = acc ? int'(req_cmd) : 0;
    e_bank = acc ? int'(req_bank) : 0;
    e_oe   = sv[n];
    e_dv   = sv[n] && !sm[n];
    e_dm   = (sv[n] && sm[n]) ? 3 : 0;
    e_dq   = sv[n] ? wdata : '0;
    if (acc && req_cmd == 2'd1) begin
      leff = (req_len == 0 || int'(req_len) > PAIRS) ? PAIRS : int'(req_len);
      for (int i = 1; i <= PAIRS; i++) begin
        sv[n + i] = 1'b1;
        sm[n + i] = (i > leff);
        sb[n + i] = int'(req_bank);
      end
    end
    if (acc && req_cmd == 2'd3) pre_edge[req_bank] = n;
    n++;
    @(negedge clk);
    chk(int'(cmd_o) == e_cmd, "R2 R10", "cmd", cmd_o, e_cmd);
    chk(int'(bank_o) == e_bank, "R2", "bank", bank_o, e_bank);
    chk(dq_oe_o == e_oe, "R3 R5", "oe", dq_oe_o, e_oe);
    chk(dval_o == e_dv, "R4", "dval", dval_o, e_dv);
    chk(int'(dm_o) == e_dm, "R4", "dm", dm_o, e_dm);
    chk(dq_o == e_dq, e_oe ? "R3" : "R9", "dq", dq_o, e_dq);
  endtask

  task automatic send(input int c, input int b, input int l, input int gap);
    req_valid = 1'b0;
    repeat (gap) step();
    req_valid = 1'b1;
    req_cmd   = 2'(c);
    req_bank  = BW'(b);
    req_len   = LENW'(l);
    do step(); while (!acc);
    req_valid = 1'b0;
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int b = 0; b < NB; b++) pre_edge[b] = -1000;
    rst = 1'b1; req_valid = 1'b0; req_cmd = 2'd0; req_bank = '0; req_len = '0; wdata = 16'hA5A5;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: outputs idle under reset
    chk(cmd_o == 2'd0 && bank_o == '0, "R1", "cmd/bank", cmd_o, 0);
    chk(!dq_oe_o && !dval_o && dm_o == 2'b00 && dq_o == '0, "R1", "data side", dq_o, 0);
    rst = 1'b0;
    step();
    // R5: full concatenation (gap 1) and truncation by a write (gap 0)
    send(1, 0, 0, 1);
    send(1, 0, 2, 1);
    send(1, 1, 1, 1);
    send(1, 2, 2, 0);
    send(1, 3, 3, 0);
    // R6: read straight after a write stalls for the write-to-read gap
    send(2, 0, 0, 0);
    // R4 and R6: truncated write, read issued during the masked tail
    send(1, 1, 1, 2);
    send(2, 1, 0, 0);
    // R7: precharge of the written bank waits; another bank goes at once
    send(1, 0, 2, 3);
    send(3, 3, 0, 0);
    send(3, 0, 0, 0);
    // R8: any command to a bank in precharge waits
    send(1, 0, 2, 0);
    send(3, 2, 0, 2);
    send(2, 2, 0, 0);
    send(3, 1, 0, 4);
    send(3, 1, 0, 0);
    // R9: idle with changing write data
    req_valid = 1'b0;
    repeat (6) step();
    for (int k = 0; k < 600 && n < MAXE - 64; k++)
      send($urandom_range(1, 3), $urandom_range(0, NB - 1),
           $urandom_range(0, 3), $urandom_range(0, 3));
    repeat (10) step();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule